// File: doc/BRIEF.md
# 32-bit Execute ALU with Immediate Extension

This block is the purely combinational execute stage of a small 32-bit RISC core. Each evaluation it receives the 6-bit major opcode, the 6-bit function field, the two register-file read values and the 16-bit immediate field of one instruction. It returns the 32-bit result, a signed-overflow flag and an illegal-operation flag, all in the same cycle.

The opcode and function field together pick both the operation and the source of the second operand. That operand is one of four things:
- the second register value;
- the immediate, sign-extended;
- the immediate, zero-extended;
- the immediate placed in the upper half of the word.

The same adder also forms the effective address for word loads and stores. Add and subtract results wrap modulo 2^32 and never trap. The overflow flag is advisory, so a later stage can act on it. An opcode and function pair that is not decoded gives a zero result and raises the illegal flag.

Top module: `mini_exec_alu`

## Requirements
- R1: With opcode 0, function 32 gives rs + rt and function 34 gives rs - rt, both wrapping modulo 2^32.
- R2: With opcode 0, function 36 gives AND, 37 gives OR, 38 gives XOR and 39 gives NOR of rs and rt; NOR of two zero operands gives 0xFFFFFFFF.
- R3: With opcode 0, function 42 gives 1 when rs is less than rt as signed two's-complement values and 0 otherwise, with bits 31:1 always zero.
- R4: Opcode 8 gives rs plus the immediate sign-extended to 32 bits (range -32768 to 32767).
- R5: Opcode 10 gives 1 when rs is signed-less-than the sign-extended immediate and 0 otherwise.
- R6: Opcodes 12, 13 and 14 give rs AND, OR and XOR with the immediate zero-extended to 32 bits.
- R7: Opcode 15 gives the immediate in bits 31:16 and zero in bits 15:0, whatever the value of rs.
- R8: Opcodes 35 and 43 give the address rs plus the sign-extended immediate, wrapping modulo 2^32.
- R9: The overflow output is 1 only for functions 32 and 34 and opcode 8, and only when the signed result does not fit in 32 bits; it is 0 for all other operations, the address forms included.
- R10: Every opcode other than 0, 8, 10, 12, 13, 14, 15, 35 and 43, and every function other than 32, 34, 36, 37, 38, 39 and 42 under opcode 0, gives result 0, overflow 0 and illegal 1. All decoded combinations give illegal 0.
- R11: Register-register forms ignore the immediate input, and immediate forms ignore rt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_opcode | input | 6 | Major opcode field |
| i_funct | input | 6 | Function field, decoded when opcode is 0 |
| i_rs_val | input | 32 | First register operand, also the address base |
| i_rt_val | input | 32 | Second register operand |
| i_imm | input | 16 | Immediate field of the instruction |
| o_result | output | 32 | Computed result or effective address |
| o_ovf | output | 1 | Signed overflow of add, subtract or add-immediate |
| o_illegal | output | 1 | Opcode and function pair is not decoded |

## Verification
A vector table tries each operation with operands whose bit patterns differ in every nibble, so a swapped logic function produces a wrong value. Operand pairs sit at the signed boundaries (0x7FFFFFFF with 1, 0x80000000 with 1, and -1 with 1). These separate true overflow from plain unsigned wrap, and separate signed from unsigned comparison. Immediates with bit 15 set separate sign extension from zero extension in each class. The address forms are fed the same overflowing sum as add-immediate, which shows that the flag stays low for them. Two full sweeps, one over all 64 opcodes and one over all 64 function codes, check the decoded set against the illegal flag. A check that varies rt under an immediate form, and one that varies the immediate under a register form, confirm the ignored inputs.

// File: rtl/mini_alu_pkg.sv
package mini_alu_pkg;

  localparam int unsigned OP_W = 6;
  localparam int unsigned FN_W = 6;

  // major opcodes
  localparam logic [OP_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OP_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [OP_W-1:0] OPC_SLTI = 6'd10;
  localparam logic [OP_W-1:0] OPC_ANDI = 6'd12;
  localparam logic [OP_W-1:0] OPC_ORI  = 6'd13;
  localparam logic [OP_W-1:0] OPC_XORI = 6'd14;
  localparam logic [OP_W-1:0] OPC_LUI  = 6'd15;
  localparam logic [OP_W-1:0] OPC_LDW  = 6'd35;
  localparam logic [OP_W-1:0] OPC_STW  = 6'd43;

  // function codes under OPC_REG
  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37;
  localparam logic [FN_W-1:0] FN_XOR = 6'd38;
  localparam logic [FN_W-1:0] FN_NOR = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR, K_SLT, K_PASSB, K_NONE
  } alu_kind_e;

  typedef enum logic [1:0] {
    B_REG, B_SEXT, B_ZEXT, B_UPPER
  } opb_src_e;

  typedef struct packed {
    alu_kind_e kind;
    opb_src_e  bsrc;
    logic      ovf_en;
    logic      illegal;
  } alu_ctrl_t;

endpackage

// File: rtl/mini_alu_decode.sv
module mini_alu_decode
  import mini_alu_pkg::*;
(
  input  logic [OP_W-1:0] i_opcode,
  input  logic [FN_W-1:0] i_funct,
  output alu_ctrl_t       o_ctrl
);

  alu_ctrl_t ctrl_d;
  logic      is_reg_form;

  assign is_reg_form = (i_opcode == OPC_REG);

  always_comb begin
    ctrl_d = '{kind: K_NONE, bsrc: B_REG, ovf_en: 1'b0, illegal: 1'b1};
    if (is_reg_form) begin
      ctrl_d.bsrc    = B_REG;
      ctrl_d.illegal = 1'b0;
      unique case (i_funct)
        FN_ADD: begin ctrl_d.kind = K_ADD; ctrl_d.ovf_en = 1'b1; end
        FN_SUB: begin ctrl_d.kind = K_SUB; ctrl_d.ovf_en = 1'b1; end
        FN_AND: ctrl_d.kind = K_AND;
        FN_OR:  ctrl_d.kind = K_OR;
        FN_XOR: ctrl_d.kind = K_XOR;
        FN_NOR: ctrl_d.kind = K_NOR;
        FN_SLT: ctrl_d.kind = K_SLT;
        default: begin
          ctrl_d.kind    = K_NONE;
          ctrl_d.illegal = 1'b1;
        end
      endcase
    end else begin
      ctrl_d.illegal = 1'b0;
      unique case (i_opcode)
        OPC_ADDI: begin ctrl_d.kind = K_ADD; ctrl_d.bsrc = B_SEXT; ctrl_d.ovf_en = 1'b1; end
        OPC_SLTI: begin ctrl_d.kind = K_SLT; ctrl_d.bsrc = B_SEXT; end
        OPC_ANDI: begin ctrl_d.kind = K_AND; ctrl_d.bsrc = B_ZEXT; end
        OPC_ORI:  begin ctrl_d.kind = K_OR;  ctrl_d.bsrc = B_ZEXT; end
        OPC_XORI: begin ctrl_d.kind = K_XOR; ctrl_d.bsrc = B_ZEXT; end
        OPC_LUI:  begin ctrl_d.kind = K_PASSB; ctrl_d.bsrc = B_UPPER; end
        OPC_LDW, OPC_STW: begin ctrl_d.kind = K_ADD; ctrl_d.bsrc = B_SEXT; end
        default: begin
          ctrl_d.kind    = K_NONE;
          ctrl_d.illegal = 1'b1;
        end
      endcase
    end
  end

  assign o_ctrl = ctrl_d;

  // R10: an illegal decode never carries a live operation or overflow enable
  always_comb begin
    a_r10_decode_consistent: assert (!ctrl_d.illegal || (ctrl_d.kind == K_NONE && !ctrl_d.ovf_en))
      else $error("R10 decode: illegal with live kind");
    // R9: the overflow enable is limited to the add and subtract kinds
    a_r9_ovf_en_kind: assert (!ctrl_d.ovf_en || ctrl_d.kind == K_ADD || ctrl_d.kind == K_SUB)
      else $error("R9 decode: overflow enable on non-arith kind");
  end

endmodule

// File: rtl/mini_alu_opsel.sv
module mini_alu_opsel
  import mini_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  opb_src_e          i_bsrc,
  input  logic [DATA_W-1:0] i_rt_val,
  input  logic [IMM_W-1:0]  i_imm,
  output logic [DATA_W-1:0] o_opb
);

  localparam int unsigned EXT_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] f_sext(input logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] f_zext(input logic [IMM_W-1:0] v);
    return {{EXT_W{1'b0}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] f_upper(input logic [IMM_W-1:0] v);
    return {v, {EXT_W{1'b0}}};
  endfunction

  logic [DATA_W-1:0] imm_sext;
  logic [DATA_W-1:0] imm_zext;
  logic [DATA_W-1:0] imm_upper;

  assign imm_sext  = f_sext(i_imm);
  assign imm_zext  = f_zext(i_imm);
  assign imm_upper = f_upper(i_imm);

  always_comb begin
    unique case (i_bsrc)
      B_REG:   o_opb = i_rt_val;
      B_SEXT:  o_opb = imm_sext;
      B_ZEXT:  o_opb = imm_zext;
      B_UPPER: o_opb = imm_upper;
      default: o_opb = '0;
    endcase
  end

  always_comb begin
    // R6: zero-extended operand has a clear upper part
    a_r6_zext_upper_clear: assert (i_bsrc != B_ZEXT || o_opb[DATA_W-1:IMM_W] == '0)
      else $error("R6 zero extension leaked upper bits");
    // R4: sign-extended operand copies bit IMM_W-1 upward and keeps the low field
    a_r4_sext_replicates: assert (i_bsrc != B_SEXT ||
                                  (o_opb[IMM_W-1:0] == i_imm &&
                                   ($signed(o_opb) < 0) == i_imm[IMM_W-1]))
      else $error("R4 sign extension mismatch");
    // R7: upper-half placement leaves the low field zero
    a_r7_upper_low_zero: assert (i_bsrc != B_UPPER || o_opb[EXT_W-1:0] == '0)
      else $error("R7 upper placement low bits set");
    // R11: immediate forms never pass rt through
    a_r11_rt_blocked: assert (i_bsrc == B_REG || o_opb == imm_sext || o_opb == imm_zext ||
                              o_opb == imm_upper)
      else $error("R11 rt reached an immediate operand");
  end

endmodule

// File: rtl/mini_alu_core.sv
module mini_alu_core
  import mini_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alu_kind_e         i_kind,
  input  logic              i_ovf_en,
  input  logic [DATA_W-1:0] i_opa,
  input  logic [DATA_W-1:0] i_opb,
  output logic [DATA_W-1:0] o_result,
  output logic              o_ovf
);

  localparam int unsigned MSB = DATA_W - 1;

  function automatic logic f_add_ovf(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                                     input logic [DATA_W-1:0] s);
    return (a[MSB] == b[MSB]) && (s[MSB] != a[MSB]);
  endfunction

  function automatic logic f_sub_ovf(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                                     input logic [DATA_W-1:0] d);
    return (a[MSB] != b[MSB]) && (d[MSB] != a[MSB]);
  endfunction

  function automatic logic f_signed_lt(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  logic [DATA_W-1:0] sum_w;
  logic [DATA_W-1:0] diff_w;
  logic              add_ovf_w;
  logic              sub_ovf_w;
  logic              lt_w;

  assign sum_w     = i_opa + i_opb;
  assign diff_w    = i_opa - i_opb;
  assign add_ovf_w = f_add_ovf(i_opa, i_opb, sum_w);
  assign sub_ovf_w = f_sub_ovf(i_opa, i_opb, diff_w);
  assign lt_w      = f_signed_lt(i_opa, i_opb);

  always_comb begin
    o_result = '0;
    o_ovf    = 1'b0;
    unique case (i_kind)
      K_ADD:   begin o_result = sum_w;  o_ovf = i_ovf_en & add_ovf_w; end
      K_SUB:   begin o_result = diff_w; o_ovf = i_ovf_en & sub_ovf_w; end
      K_AND:   o_result = i_opa & i_opb;
      K_OR:    o_result = i_opa | i_opb;
      K_XOR:   o_result = i_opa ^ i_opb;
      K_NOR:   o_result = ~(i_opa | i_opb);
      K_SLT:   o_result = {{(DATA_W-1){1'b0}}, lt_w};
      K_PASSB: o_result = i_opb;
      default: begin o_result = '0; o_ovf = 1'b0; end
    endcase
  end

  always_comb begin
    // R3: signed compare agrees with the sign of the difference corrected by overflow
    a_r3_lt_matches_diff: assert (lt_w == (diff_w[MSB] ^ sub_ovf_w))
      else $error("R3 compare disagrees with subtract sign");
    // R3 / R5: set-less-than result is 0 or 1
    a_r3_slt_boolean: assert (i_kind != K_SLT || o_result[DATA_W-1:1] == '0)
      else $error("R3 set-less-than upper bits set");
    // R1: the difference and the operand b add back to operand a
    a_r1_sub_inverse: assert (diff_w + i_opb == i_opa)
      else $error("R1 subtract not inverse of add");
    // R9: overflow only leaves the core for add and subtract kinds
    a_r9_ovf_only_arith: assert (!o_ovf || i_kind == K_ADD || i_kind == K_SUB)
      else $error("R9 overflow on non-arith kind");
  end

endmodule

// File: rtl/mini_exec_alu.sv
module mini_exec_alu
  import mini_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [5:0]        i_opcode,
  input  logic [5:0]        i_funct,
  input  logic [DATA_W-1:0] i_rs_val,
  input  logic [DATA_W-1:0] i_rt_val,
  input  logic [IMM_W-1:0]  i_imm,
  output logic [DATA_W-1:0] o_result,
  output logic              o_ovf,
  output logic              o_illegal
);

  alu_ctrl_t         ctrl_w;
  logic [DATA_W-1:0] opb_w;
  logic [DATA_W-1:0] core_res_w;
  logic              core_ovf_w;

  mini_alu_decode u_decode (
    .i_opcode (i_opcode),
    .i_funct  (i_funct),
    .o_ctrl   (ctrl_w)
  );

  mini_alu_opsel #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_opsel (
    .i_bsrc   (ctrl_w.bsrc),
    .i_rt_val (i_rt_val),
    .i_imm    (i_imm),
    .o_opb    (opb_w)
  );

  mini_alu_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .i_kind   (ctrl_w.kind),
    .i_ovf_en (ctrl_w.ovf_en),
    .i_opa    (i_rs_val),
    .i_opb    (opb_w),
    .o_result (core_res_w),
    .o_ovf    (core_ovf_w)
  );

  assign o_result  = ctrl_w.illegal ? '0 : core_res_w;
  assign o_ovf     = core_ovf_w & ~ctrl_w.illegal;
  assign o_illegal = ctrl_w.illegal;

  always_comb begin
    // R10: illegal outputs are quiet
    a_r10_illegal_quiet: assert (!o_illegal || (o_result == '0 && !o_ovf))
      else $error("R10 illegal op drove result or overflow");
    // R7: upper-immediate load clears the low half
    a_r7_lui_low_zero: assert (i_opcode != OPC_LUI || o_result[DATA_W-IMM_W-1:0] == '0)
      else $error("R7 upper load low half not zero");
    // R9 / R8: address forms never raise overflow
    a_r9_addr_no_ovf: assert (!(i_opcode == OPC_LDW || i_opcode == OPC_STW) || !o_ovf)
      else $error("R9 overflow raised on address form");
  end

endmodule

// File: tb/tb_mini_exec_alu.sv
module tb_mini_exec_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode;
  logic [5:0]  funct;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic [15:0] imm;
  logic [31:0] result;
  logic        ovf;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mini_exec_alu dut (
    .i_opcode  (opcode),
    .i_funct   (funct),
    .i_rs_val  (rs_val),
    .i_rt_val  (rt_val),
    .i_imm     (imm),
    .o_result  (result),
    .o_ovf     (ovf),
    .o_illegal (illegal)
  );

  localparam int NV = 29;
  // columns: opcode, function, rs, rt, imm, expected result, overflow, illegal, requirement
  localparam logic [5:0]  V_OP  [NV] = '{0,0,0,0,0, 0,0,0,0,0, 0,0,0, 8,8, 10,10, 12,13,14, 15, 35,43,43, 0,2,63, 0,0};
  localparam logic [5:0]  V_FN  [NV] = '{32,32,32,34,34, 36,37,38,39,39, 42,42,42, 0,0, 0,0, 0,0,0, 0, 0,0,0, 33,32,32, 32,42};
  localparam logic [31:0] V_RS  [NV] = '{
    32'd5, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'd16, 32'h80000000,
    32'hF0F0F0F0, 32'hF0F0F0F0, 32'hF0F0F0F0, 32'h0, 32'hF0F0F0F0,
    32'hFFFFFFFF, 32'd1, 32'd5,
    32'd100, 32'h7FFFFFFF,
    32'hFFFFFFFE, 32'h0,
    32'hFFFFFFFF, 32'h12340000, 32'hFFFFFFFF,
    32'hFFFFFFFF,
    32'h1000, 32'h100, 32'h7FFFFFFF,
    32'd5, 32'd5, 32'd5,
    32'd1, 32'h80000000};
  localparam logic [31:0] V_RT  [NV] = '{
    32'd7, 32'd1, 32'd1, 32'd3, 32'd1,
    32'hFF00FF00, 32'hFF00FF00, 32'hFF00FF00, 32'h0, 32'h0F0F0000,
    32'd1, 32'hFFFFFFFF, 32'd5,
    32'hDEADBEEF, 32'hDEADBEEF,
    32'hDEADBEEF, 32'hDEADBEEF,
    32'hDEADBEEF, 32'hDEADBEEF, 32'hDEADBEEF,
    32'hDEADBEEF,
    32'hDEADBEEF, 32'hDEADBEEF, 32'hDEADBEEF,
    32'd7, 32'd7, 32'd7,
    32'd2, 32'h7FFFFFFF};
  localparam logic [15:0] V_IMM [NV] = '{
    0,0,0,0,0, 0,0,0,0,0, 0,0,0,
    16'hFFFF, 16'h0001,
    16'hFFFF, 16'h8000,
    16'h8001, 16'hFFFF, 16'h00FF,
    16'h2110,
    16'hFFFC, 16'h0028, 16'h0001,
    0,0,0,
    16'hFFFF, 16'hFFFF};
  localparam logic [31:0] V_RES [NV] = '{
    32'd12, 32'h0, 32'h80000000, 32'd13, 32'h7FFFFFFF,
    32'hF000F000, 32'hFFF0FFF0, 32'h0FF00FF0, 32'hFFFFFFFF, 32'h00000F0F,
    32'd1, 32'd0, 32'd0,
    32'h63, 32'h80000000,
    32'd1, 32'd0,
    32'h00008001, 32'h1234FFFF, 32'hFFFFFF00,
    32'h21100000,
    32'h0FFC, 32'h128, 32'h80000000,
    32'h0, 32'h0, 32'h0,
    32'd3, 32'd1};
  localparam logic        V_OVF [NV] = '{0,0,1,0,1, 0,0,0,0,0, 0,0,0, 0,1, 0,0, 0,0,0, 0, 0,0,0, 0,0,0, 0,0};
  localparam logic        V_ILL [NV] = '{0,0,0,0,0, 0,0,0,0,0, 0,0,0, 0,0, 0,0, 0,0,0, 0, 0,0,0, 1,1,1, 0,0};
  // R1 add/sub, R2 logic, R3 slt, R4 addi, R9 overflow, R5 slti, R6 logic-imm,
  // R7 upper load, R8 address, R10 illegal, R11 ignored immediate
  localparam int          V_REQ [NV] = '{1,1,9,1,9, 2,2,2,2,2, 3,3,3, 4,9, 5,5, 6,6,6, 7, 8,8,9, 10,10,10, 11,3};

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im);
    @(posedge clk);
    opcode = op; funct = fn; rs_val = a; rt_val = b; imm = im;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic eo, input logic ei);
    checks++;
    if (result !== er || ovf !== eo || illegal !== ei) begin
      errors++;
      $display("FAIL %s: got result=%h ovf=%b ill=%b expected result=%h ovf=%b ill=%b",
               tag, result, ovf, illegal, er, eo, ei);
    end
  endtask

  function automatic bit legal_opcode(input int op);
    return op == 0 || op == 8 || op == 10 || op == 12 || op == 13 || op == 14 ||
           op == 15 || op == 35 || op == 43;
  endfunction

  function automatic bit legal_funct(input int fn);
    return fn == 32 || fn == 34 || fn == 36 || fn == 37 || fn == 38 || fn == 39 || fn == 42;
  endfunction

  initial begin
    opcode = '0; funct = '0; rs_val = '0; rt_val = '0; imm = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: all-zero instruction word (function 0) is not decoded
    check("R10 reset zero word", 32'h0, 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      apply(V_OP[i], V_FN[i], V_RS[i], V_RT[i], V_IMM[i]);
      check($sformatf("R%0d vector %0d", V_REQ[i], i), V_RES[i], V_OVF[i], V_ILL[i]);
    end

    // R7: rs has no effect on the upper-immediate load
    apply(6'd15, 6'd0, 32'h0, 32'h0, 16'hFFFF);
    check("R7 lui rs zero", 32'hFFFF0000, 1'b0, 1'b0);

    // R11: rt has no effect under an immediate form (ori rs=0xF0 imm=0x0F)
    for (int k = 0; k < 4; k++) begin
      apply(6'd13, 6'd0, 32'h000000F0, 32'h1 << (k * 9), 16'h000F);
      check("R11 ori rt ignored", 32'h000000FF, 1'b0, 1'b0);
    end

    // R10: sweep every opcode with a legal function
    for (int op = 0; op < 64; op++) begin
      apply(op[5:0], 6'd32, 32'd3, 32'd4, 16'd5);
      checks++;
      if (illegal !== !legal_opcode(op) || (illegal && (result !== 32'h0 || ovf !== 1'b0))) begin
        errors++;
        $display("FAIL R10 opcode %0d: got ill=%b result=%h expected ill=%b",
                 op, illegal, result, !legal_opcode(op));
      end
    end

    // R10: sweep every function code under opcode 0
    for (int fn = 0; fn < 64; fn++) begin
      apply(6'd0, fn[5:0], 32'd3, 32'd4, 16'd5);
      checks++;
      if (illegal !== !legal_funct(fn) || (illegal && result !== 32'h0)) begin
        errors++;
        $display("FAIL R10 funct %0d: got ill=%b result=%h expected ill=%b",
                 fn, illegal, result, !legal_funct(fn));
      end
    end

    // R9: subtract of equal-sign operands never overflows
    apply(6'd0, 6'd34, 32'h80000000, 32'h80000000, 16'h0);
    check("R9 sub same sign", 32'h0, 1'b0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule